// File: doc/BRIEF.md
# Cascaded Search Result Latency Pipeline

This block sits at the result end of one device in a depth-cascaded lookup table. Every cycle the lookup core presents one operation: a search or an SRAM read. The operation carries a flag saying whether this device owns it, and the SRAM address that belongs to it. The block holds each operation for a fixed number of cycles. It then drives the external SRAM address and strobes at the base latency, and the hit flag, valid strobe and read acknowledge at the base latency plus an extra hit delay.

Each output group has its own drive enable, so that several devices can share the result and SRAM lines. A device drives a group when it owns the cycle. A device that carries the matching "last" flag also drives that group in cycles that no device claims. In those cycles it drives defined idle values: a miss answer on the result lines, and all ones with inactive strobes on the SRAM lines. The SRAM output-enable line is driven only by the device that is last on the SRAM bus.

A configuration write loads four values: a table-size code that sets the base latency, an extra hit-delay code, and the two last-device flags. A write that carries the reserved table-size code is dropped as a whole and raises an error flag.

Top module: `srch_lat_pipe`

## Requirements
- R1: After a synchronous active-low reset, the block is in the following state. All drive enables (`res_oe`, `bus_oe`, `sram_oe_n_en`) are 0. `res_hit`, `res_valid`, `res_ack` and `cfg_err` are 0. `sram_addr` is all ones. Every active-low SRAM strobe is 1. The configuration is table code 00, hit delay 0, and both last flags clear.
- R2: The table-size code `cfg_tbl` sets the base latency L. Code 00 gives L = 4, code 01 gives L = 5 and code 10 gives L = 6. An owned operation sampled at clock edge k drives its address on `sram_addr`, with `sram_ce_n` = 0, `sram_ale_n` = 0 and `bus_oe` = 1. These values appear for exactly one cycle, after edge k+L.
- R3: The hit-delay code `cfg_hlat` is read as an unsigned number H from 0 to 7. The result outputs of an operation sampled at edge k appear for exactly one cycle, after edge k+L+H.
- R4: An owned search (`op_own` = 1, `op_search` = 1) gives `res_hit` = 1, `res_valid` = 1 and `res_oe` = 1 in its result cycle. `res_hit` is never 1 without `res_valid`.
- R5: A search that this device does not own, on a device whose last-in-cascade flag is set, gives `res_oe` = 1, `res_valid` = 1 and `res_hit` = 0 in its result cycle.
- R6: On a device whose last-in-cascade flag is set, every cycle that carries no search result drives `res_oe` = 1, `res_hit` = 0 and `res_valid` = 0.
- R7: Some outputs are released in a cycle, with enable 0. `res_oe` is 0 when the last-in-cascade flag is clear and the device owns no result that cycle. `bus_oe` is 0 when the last-on-bus flag is clear and the device owns no SRAM cycle.
- R8: On a device whose last-on-bus flag is set, every SRAM cycle that it does not own drives `bus_oe` = 1, `sram_addr` all ones, and `sram_ce_n`, `sram_we_n` and `sram_ale_n` all 1.
- R9: `sram_oe_n_en` equals the stored last-on-bus flag in every cycle. `sram_oe_n` is 0 only in this device's owned SRAM cycles.
- R10: An owned SRAM read (`op_search` = 0) gives `res_ack` = 1 in its result cycle, after edge k+L+H, and `res_valid` stays 0. The SRAM address appears at L, as in R2.
- R11: A configuration write whose table code is 11 leaves all four stored fields unchanged and sets `cfg_err` to 1. The next legal write loads its fields and clears `cfg_err`.
- R12: Operations presented on consecutive cycles each come out in order on consecutive cycles, each at its own fixed latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tbl | input | 2 | Table-size code (00/01/10, 11 reserved) |
| cfg_hlat | input | HLAT_W | Extra hit delay in cycles |
| cfg_last_casc | input | 1 | Last device in the cascade |
| cfg_last_bus | input | 1 | Last device on the SRAM bus |
| op_vld | input | 1 | An operation is present this cycle |
| op_search | input | 1 | 1 = search, 0 = SRAM read |
| op_own | input | 1 | This device owns the operation |
| op_addr | input | 22 | SRAM address of the operation |
| res_hit | output | 1 | Hit flag |
| res_valid | output | 1 | Search result valid strobe |
| res_ack | output | 1 | SRAM read acknowledge |
| res_oe | output | 1 | Drive enable for hit, valid and ack |
| sram_addr | output | 22 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ale_n | output | 1 | SRAM address latch enable, active low |
| bus_oe | output | 1 | Drive enable for address, CE, WE and ALE |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_oe_n_en | output | 1 | Drive enable for sram_oe_n |
| cfg_err | output | 1 | Last configuration write used the reserved code |

## Verification
The assertions check on every cycle the relations that hold whatever the traffic. A hit is always valid and driven, and an acknowledge never coincides with a valid strobe. A driven bus with chip enable high always shows the idle address and strobes, and the output-enable drive tracks the stored flag. The stored table code is never the reserved value, and a reserved write always sets the error and holds the code. Only the directed scenarios can show the timing itself. That covers the exact cycle in which each result and address appears for every table code and several hit delays, the release and default behaviour under each flag setting, and the order of back-to-back operations.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
// slp_pkg: shared constants and the pipeline entry type for the search
// latency pipeline. Assumes a fixed 22-bit SRAM address width.
package slp_pkg;
    localparam int ADDR_W = 22;
    localparam logic [1:0] TBL_RSVD = 2'b11;

    // One operation as it travels through the delay line.
    typedef struct packed {
        logic              vld;
        logic              search;
        logic              own;
        logic [ADDR_W-1:0] addr;
    } op_t;
endpackage

// File: rtl/slp_cfg.sv
`timescale 1ns/1ps
// slp_cfg: holds the latency configuration and turns it into two tap
// indices into the delay line. A write with the reserved table code is
// dropped as a whole and flags an error. Assumes the latency fields are
// stable while operations are in flight.
module slp_cfg #(
    parameter int MIN_LAT = 4,
    parameter int HLAT_W  = 3,
    parameter int IW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        tbl_in,
    input  logic [HLAT_W-1:0] hlat_in,
    input  logic              last_casc_in,
    input  logic              last_bus_in,
    output logic [1:0]        tbl_q,
    output logic              last_casc_q,
    output logic              last_bus_q,
    output logic              err_q,
    output logic [IW-1:0]     bus_tap,
    output logic [IW-1:0]     hit_tap
);
    logic [HLAT_W-1:0] hlat_q;

    // Load legal writes; keep the old fields and flag reserved ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q       <= 2'b00;
            hlat_q      <= '0;
            last_casc_q <= 1'b0;
            last_bus_q  <= 1'b0;
            err_q       <= 1'b0;
        end else if (wr) begin
            if (tbl_in == slp_pkg::TBL_RSVD) begin
                err_q <= 1'b1;
            end else begin
                tbl_q       <= tbl_in;
                hlat_q      <= hlat_in;
                last_casc_q <= last_casc_in;
                last_bus_q  <= last_bus_in;
                err_q       <= 1'b0;
            end
        end
    end

    // Tap index = latency - 1, because the output stage adds one register.
    always_comb begin
        bus_tap = IW'(MIN_LAT - 1) + IW'(tbl_q);
        hit_tap = bus_tap + IW'(hlat_q);
    end
endmodule

// File: rtl/slp_delay.sv
`timescale 1ns/1ps
// slp_delay: fixed-depth shift register of operations with two
// run-time selected taps. Every entry moves one stage per cycle, so
// back-to-back operations keep their order and spacing.
module slp_delay #(
    parameter int DEPTH = 13,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slp_pkg::op_t  in_op,
    input  logic [IW-1:0] bus_tap,
    input  logic [IW-1:0] hit_tap,
    output slp_pkg::op_t  bus_ent,
    output slp_pkg::op_t  hit_ent
);
    slp_pkg::op_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        if (i == 0) begin : g_head
            // First stage captures the incoming operation.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= in_op;
            end
        end else begin : g_body
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    // Select the two taps; an index past the end reads as empty.
    always_comb begin
        bus_ent = '0;
        hit_ent = '0;
        if (bus_tap < IW'(DEPTH)) bus_ent = stg[bus_tap];
        if (hit_tap < IW'(DEPTH)) hit_ent = stg[hit_tap];
    end
endmodule

// File: rtl/slp_drive.sv
`timescale 1ns/1ps
// slp_drive: turns the two tapped entries into registered result and
// SRAM outputs with per-group drive enables and idle defaults for a
// last device. Only reads are issued to the SRAM, so write enable stays
// inactive.
module slp_drive (
    input  logic                       clk,
    input  logic                       rst_n,
    input  slp_pkg::op_t               bus_ent,
    input  slp_pkg::op_t               hit_ent,
    input  logic                       last_casc,
    input  logic                       last_bus,
    output logic                       res_hit,
    output logic                       res_valid,
    output logic                       res_ack,
    output logic                       res_oe,
    output logic [slp_pkg::ADDR_W-1:0] sram_addr,
    output logic                       sram_ce_n,
    output logic                       sram_we_n,
    output logic                       sram_ale_n,
    output logic                       bus_oe,
    output logic                       sram_oe_n,
    output logic                       sram_oe_n_en
);
    logic own_bus, own_res, res_srch, res_rd;

    // Decode ownership and kind of the entries at the two taps.
    always_comb begin
        own_bus  = bus_ent.vld & bus_ent.own;
        own_res  = hit_ent.vld & hit_ent.own;
        res_srch = hit_ent.vld & hit_ent.search;
        res_rd   = hit_ent.vld & ~hit_ent.search;
    end

    // Register the result group: owner answers, last device defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit   <= 1'b0;
            res_valid <= 1'b0;
            res_ack   <= 1'b0;
            res_oe    <= 1'b0;
        end else begin
            res_hit   <= own_res & res_srch;
            res_valid <= res_srch & (own_res | last_casc);
            res_ack   <= own_res & res_rd;
            res_oe    <= own_res | last_casc;
        end
    end

    // Register the SRAM group: owner drives its address, else idle values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr    <= '1;
            sram_ce_n    <= 1'b1;
            sram_we_n    <= 1'b1;
            sram_ale_n   <= 1'b1;
            bus_oe       <= 1'b0;
            sram_oe_n    <= 1'b1;
            sram_oe_n_en <= 1'b0;
        end else begin
            sram_addr    <= own_bus ? bus_ent.addr : '1;
            sram_ce_n    <= ~own_bus;
            sram_we_n    <= 1'b1;
            sram_ale_n   <= ~own_bus;
            bus_oe       <= own_bus | last_bus;
            sram_oe_n    <= ~own_bus;
            sram_oe_n_en <= last_bus;
        end
    end
endmodule

// File: rtl/srch_lat_pipe.sv
`timescale 1ns/1ps
// srch_lat_pipe: delays each search or SRAM read by a configured latency
// and drives the shared result and SRAM lines of one cascaded device.
// Assumes at most one operation per cycle and a stable configuration
// while operations are in flight.
module srch_lat_pipe #(
    parameter int MIN_LAT = 4,
    parameter int HLAT_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [1:0]                 cfg_tbl,
    input  logic [HLAT_W-1:0]          cfg_hlat,
    input  logic                       cfg_last_casc,
    input  logic                       cfg_last_bus,
    input  logic                       op_vld,
    input  logic                       op_search,
    input  logic                       op_own,
    input  logic [slp_pkg::ADDR_W-1:0] op_addr,
    output logic                       res_hit,
    output logic                       res_valid,
    output logic                       res_ack,
    output logic                       res_oe,
    output logic [slp_pkg::ADDR_W-1:0] sram_addr,
    output logic                       sram_ce_n,
    output logic                       sram_we_n,
    output logic                       sram_ale_n,
    output logic                       bus_oe,
    output logic                       sram_oe_n,
    output logic                       sram_oe_n_en,
    output logic                       cfg_err
);
    localparam int MAX_BASE = MIN_LAT + 2;
    localparam int DEPTH    = MAX_BASE + (2**HLAT_W) - 1;
    localparam int IW       = $clog2(DEPTH + 1);

    logic [1:0]    tbl_q;
    logic          last_casc_q, last_bus_q;
    logic [IW-1:0] bus_tap, hit_tap;
    slp_pkg::op_t  in_op, bus_ent, hit_ent;

    // Pack the incoming operation; an absent one enters as empty.
    always_comb begin
        in_op.vld    = op_vld;
        in_op.search = op_vld & op_search;
        in_op.own    = op_vld & op_own;
        in_op.addr   = op_addr;
    end

    slp_cfg #(.MIN_LAT(MIN_LAT), .HLAT_W(HLAT_W), .IW(IW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .tbl_in(cfg_tbl),
        .hlat_in(cfg_hlat), .last_casc_in(cfg_last_casc),
        .last_bus_in(cfg_last_bus), .tbl_q(tbl_q),
        .last_casc_q(last_casc_q), .last_bus_q(last_bus_q),
        .err_q(cfg_err), .bus_tap(bus_tap), .hit_tap(hit_tap)
    );

    slp_delay #(.DEPTH(DEPTH), .IW(IW)) u_delay (
        .clk(clk), .rst_n(rst_n), .in_op(in_op), .bus_tap(bus_tap),
        .hit_tap(hit_tap), .bus_ent(bus_ent), .hit_ent(hit_ent)
    );

    slp_drive u_drive (
        .clk(clk), .rst_n(rst_n), .bus_ent(bus_ent), .hit_ent(hit_ent),
        .last_casc(last_casc_q), .last_bus(last_bus_q),
        .res_hit(res_hit), .res_valid(res_valid), .res_ack(res_ack),
        .res_oe(res_oe), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_ale_n(sram_ale_n), .bus_oe(bus_oe),
        .sram_oe_n(sram_oe_n), .sram_oe_n_en(sram_oe_n_en)
    );
endmodule

// File: rtl/slp_chk.sv
`timescale 1ns/1ps
// slp_chk: cycle-by-cycle properties of srch_lat_pipe, attached by bind.
module slp_chk (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_wr,
    input logic [1:0]                 cfg_tbl,
    input logic                       res_hit,
    input logic                       res_valid,
    input logic                       res_ack,
    input logic                       res_oe,
    input logic [slp_pkg::ADDR_W-1:0] sram_addr,
    input logic                       sram_ce_n,
    input logic                       sram_we_n,
    input logic                       sram_ale_n,
    input logic                       bus_oe,
    input logic                       sram_oe_n_en,
    input logic                       cfg_err,
    input logic [1:0]                 tbl_q,
    input logic                       last_bus_q
);
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_valid && res_oe)); // R4
    AST_VALID_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_oe); // R5
    AST_ACK_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_ack |-> !res_valid); // R10
    AST_IDLE_BUS_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && sram_ce_n) |-> (sram_addr == '1 && sram_we_n && sram_ale_n)); // R8
    AST_CE_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (sram_ce_n == sram_ale_n)); // R2
    AST_OE_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sram_oe_n_en == $past(last_bus_q))); // R9
    AST_NO_RSVD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q != slp_pkg::TBL_RSVD); // R11
    AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_tbl == slp_pkg::TBL_RSVD) |=> (cfg_err && $stable(tbl_q))); // R11
endmodule

bind srch_lat_pipe slp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tbl(cfg_tbl),
    .res_hit(res_hit), .res_valid(res_valid), .res_ack(res_ack),
    .res_oe(res_oe), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_ale_n(sram_ale_n), .bus_oe(bus_oe),
    .sram_oe_n_en(sram_oe_n_en), .cfg_err(cfg_err), .tbl_q(tbl_q),
    .last_bus_q(last_bus_q)
);

// File: tb/test_srch_lat_pipe.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_srch_lat_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_tbl = '0;
    logic [2:0]  cfg_hlat = '0;
    logic        cfg_last_casc = 1'b0, cfg_last_bus = 1'b0;
    logic        op_vld = 1'b0, op_search = 1'b0, op_own = 1'b0;
    logic [21:0] op_addr = '0;
    logic        res_hit, res_valid, res_ack, res_oe;
    logic [21:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_ale_n, bus_oe, sram_oe_n, sram_oe_n_en, cfg_err;

    int total = 0;
    int bad = 0;
    localparam logic [21:0] ONES = 22'h3FFFFF;

    always #10 clk = ~clk;

    srch_lat_pipe i_srch_lat_pipe (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tbl(cfg_tbl),
        .cfg_hlat(cfg_hlat), .cfg_last_casc(cfg_last_casc),
        .cfg_last_bus(cfg_last_bus), .op_vld(op_vld), .op_search(op_search),
        .op_own(op_own), .op_addr(op_addr), .res_hit(res_hit),
        .res_valid(res_valid), .res_ack(res_ack), .res_oe(res_oe),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_ale_n(sram_ale_n), .bus_oe(bus_oe), .sram_oe_n(sram_oe_n),
        .sram_oe_n_en(sram_oe_n_en), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(logic [1:0] tbl, logic [2:0] hl, logic lc, logic lb);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_tbl = tbl; cfg_hlat = hl;
        cfg_last_casc = lc; cfg_last_bus = lb;
        @(negedge clk);
        cfg_wr = 1'b0;
        idle(16);
    endtask

    // Check every output at one step against the expected model values.
    task automatic chk_all(string tag, logic b_own, logic [21:0] b_addr, logic r_step,
                           logic vld, logic srch, logic own, logic lc, logic lb);
        logic e_boe;
        e_boe = b_own || lb;
        chk(tag, "bus_oe", bus_oe, e_boe);
        chk(tag, "ce_n", sram_ce_n, !b_own);
        chk(tag, "ale_n", sram_ale_n, !b_own);
        chk(tag, "oe_n", sram_oe_n, !b_own);
        if (e_boe) begin
            chk(tag, "addr", sram_addr, b_own ? b_addr : ONES);
            chk(tag, "we_n", sram_we_n, 1'b1);
        end
        chk(tag, "oe_n_en", sram_oe_n_en, lb);
        chk(tag, "res_oe", res_oe, (r_step && vld && own) || lc);
        chk(tag, "hit", res_hit, r_step && vld && own && srch);
        chk(tag, "valid", res_valid, r_step && vld && srch && (own || lc));
        chk(tag, "ack", res_ack, r_step && vld && own && !srch);
    endtask

    // One operation, then every cycle until past its result cycle.
    task automatic run_single(string tag, int base, int hl, logic vld, logic srch,
                              logic own, logic [21:0] addr, logic lc, logic lb);
        @(negedge clk);
        op_vld = vld; op_search = srch; op_own = own; op_addr = addr;
        for (int n = 1; n <= base + hl + 2; n++) begin
            @(negedge clk);
            if (n == 1) begin op_vld = 1'b0; op_search = 1'b0; op_own = 1'b0; end
            chk_all(tag, vld && own && (n == base + 1), addr, n == base + hl + 1,
                    vld, srch, own, lc, lb);
        end
        idle(4);
    endtask

    task automatic t_reset;
        chk("R1", "res_oe", res_oe, 0);
        chk("R1", "bus_oe", bus_oe, 0);
        chk("R1", "oe_n_en", sram_oe_n_en, 0);
        chk("R1", "hit", res_hit, 0);
        chk("R1", "valid", res_valid, 0);
        chk("R1", "ack", res_ack, 0);
        chk("R1", "cfg_err", cfg_err, 0);
        chk("R1", "addr", sram_addr, ONES);
        chk("R1", "strobes", {sram_ce_n, sram_we_n, sram_ale_n, sram_oe_n}, 4'hF);
        // R1: default latency 4 with no hit delay
        run_single("R1", 4, 0, 1, 1, 1, 22'h000123, 0, 0);
    endtask

    task automatic t_base_latency;
        for (int t = 0; t < 3; t++) begin
            set_cfg(2'(t), 3'd0, 0, 0);
            run_single("R2", 4 + t, 0, 1, 1, 1, 22'h0A5000 + 22'(t), 0, 0);
        end
    endtask

    task automatic t_hit_delay;
        set_cfg(2'b01, 3'd3, 0, 0);
        run_single("R3", 5, 3, 1, 1, 1, 22'h12345, 0, 0);
        set_cfg(2'b10, 3'd7, 0, 0);
        run_single("R3", 6, 7, 1, 1, 1, 22'h2ABCD, 0, 0);
        set_cfg(2'b00, 3'd1, 0, 0);
        run_single("R4", 4, 1, 1, 1, 1, 22'h3FFFFE, 0, 0);
    endtask

    task automatic t_cascade_flags;
        set_cfg(2'b00, 3'd2, 1, 0);
        run_single("R5", 4, 2, 1, 1, 0, 22'h00777, 1, 0);
        run_single("R6", 4, 2, 0, 0, 0, 22'h0, 1, 0);
        set_cfg(2'b00, 3'd2, 0, 0);
        run_single("R7", 4, 2, 1, 1, 0, 22'h00777, 0, 0);
        run_single("R7", 4, 2, 1, 0, 0, 22'h00888, 0, 0);
    endtask

    task automatic t_bus_defaults;
        set_cfg(2'b01, 3'd0, 0, 1);
        run_single("R8", 5, 0, 0, 0, 0, 22'h0, 0, 1);
        run_single("R9", 5, 0, 1, 1, 1, 22'h15555, 0, 1);
        run_single("R8", 5, 0, 1, 1, 0, 22'h15555, 0, 1);
    endtask

    task automatic t_read_ack;
        set_cfg(2'b10, 3'd5, 1, 0);
        run_single("R10", 6, 5, 1, 0, 1, 22'h0BEEF, 1, 0);
        set_cfg(2'b00, 3'd0, 0, 0);
        run_single("R10", 4, 0, 1, 0, 1, 22'h0CAFE, 0, 0);
    endtask

    task automatic t_reserved;
        set_cfg(2'b01, 3'd0, 0, 0);
        set_cfg(2'b11, 3'd4, 1, 1);
        chk("R11", "cfg_err", cfg_err, 1);
        run_single("R11", 5, 0, 1, 1, 1, 22'h01111, 0, 0);
        set_cfg(2'b00, 3'd0, 0, 0);
        chk("R11", "cfg_err", cfg_err, 0);
        run_single("R11", 4, 0, 1, 1, 1, 22'h02222, 0, 0);
    endtask

    task automatic t_back_to_back;
        logic        own_k [3];
        logic [21:0] addr_k [3];
        int base, hl;
        base = 5; hl = 2;
        own_k[0] = 1; own_k[1] = 0; own_k[2] = 1;
        addr_k[0] = 22'h0AAA0; addr_k[1] = 22'h0BBB1; addr_k[2] = 22'h0CCC2;
        set_cfg(2'b01, 3'(hl), 1, 0);
        @(negedge clk);
        op_vld = 1; op_search = 1; op_own = own_k[0]; op_addr = addr_k[0];
        for (int n = 1; n <= base + hl + 4; n++) begin
            logic b_own, r_own, r_step;
            logic [21:0] b_addr;
            @(negedge clk);
            if (n < 3) begin op_own = own_k[n]; op_addr = addr_k[n]; end
            else begin op_vld = 0; op_search = 0; op_own = 0; end
            b_own = 0; b_addr = '0; r_own = 0; r_step = 0;
            for (int k = 0; k < 3; k++) begin
                if (n == base + 1 + k) begin b_own = own_k[k]; b_addr = addr_k[k]; end
                if (n == base + hl + 1 + k) begin r_step = 1; r_own = own_k[k]; end
            end
            // R12: each of the three searches at its own cycle, in order
            chk_all("R12", b_own, b_addr, r_step, 1, 1, r_own, 1, 0);
        end
        idle(4);
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_latency();
        t_hit_delay();
        t_cascade_flags();
        t_bus_defaults();
        t_read_ack();
        t_reserved();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule